// File: doc/BRIEF.md
# Vertical Microinstruction Control Decoder

This block is the decode stage of a microprogrammed control unit for a three-bus processor datapath. A microprogram address selects a word from a small preloaded control store. The word is vertically encoded: each register selection is a 4-bit code rather than a line per register. The block splits the word into its fields and registers the result as the control word for the datapath. That word holds one-hot destination-load lines, one-hot enables for the two source buses, an ALU operation code, and memory read and write strobes. It also passes the select, condition and branch-address fields through to the next-address logic.

In every destination and source field, the all-zero code means that nothing is selected, so no line is asserted for it. The memory field has two legal operations. Its fourth pattern is illegal: it drives no strobe and raises an error flag instead. The instruction fetch routine is stored from location 0 onward. It loads the memory address register from the program counter, reads memory, loads the instruction register from the memory data register, and advances the program counter by four.

Top module: `ucs_decoder`

## Requirements
- R1: All outputs are registered. The control word for the address present at a rising edge of `clk` appears just after that edge and holds until the next edge.
- R2: A destination code k in 1..15 asserts only `dst_load[k]`. Code 0 asserts no line of `dst_load`.
- R3: The two source fields decode onto `src1_en` and `src2_en` by the same rule: code k in 1..15 asserts only line k, and code 0 asserts nothing.
- R4: `alu_op` carries the 4-bit function code unchanged. The codes are: 0 pass input 1, 1 add, 2 subtract, 3 multiply, 4 divide, 5 AND, 6 OR, 7 shift left, 8 shift right.
- R5: Memory field 01 asserts only `mem_rd`, 10 asserts only `mem_wr`, and 00 asserts neither.
- R6: Memory field 11 asserts neither strobe and sets `mem_err`. Every other value leaves `mem_err` low.
- R7: The word is laid out from the MSB as follows: destination [28:25], ALU [24:21], source 1 [20:17], source 2 [16:13], memory [12:11], select [10:9], condition [8:6], branch address [5:0]. Select, condition and branch address appear unchanged on `nxt_sel`, `cond`, `br_addr`.
- R8: The register codes are IR 3, PC 8, MDR 9 and MAR 10. Source code 1 is Rs1, 2 is Rs2, 6 is constant zero and 7 is constant four. The store contents, given as dest/alu/src1/src2/mem/sel/cond/br, are:
  - location 0: 10/0/8/0/00/0/0/0
  - location 1: 0/0/0/0/01/0/0/0
  - location 2: 3/0/9/0/00/0/0/0
  - location 3: 8/1/8/7/00/1/0/0
  - location 4: 0/0/0/0/10/0/0/0
  - location 5: 9/0/10/0/11/0/0/0
  - location 6: 0/2/1/6/00/2/5/22
  - location 7: 1/8/1/2/00/0/0/0
- R9: When `rst_n` is low at a rising edge, every output is cleared at that edge, whatever the address.
- R10: Every location from 8 upward holds the all-zero word, so no strobe and no error is asserted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uaddr | input | 6 | Microprogram address |
| dst_load | output | 16 | One-hot destination load lines |
| src1_en | output | 16 | One-hot source bus 1 enables |
| src2_en | output | 16 | One-hot source bus 2 enables |
| alu_op | output | 4 | ALU function code |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_err | output | 1 | Illegal memory code flag |
| nxt_sel | output | 2 | Next-address select field |
| cond | output | 3 | Branch condition field |
| br_addr | output | 6 | Branch target field |

## Verification
Two pairs of functions can fall in the same cycle, and both are tested.

The first pair is the illegal-memory error and a live destination load. Location 5 carries both, so the bench checks in one cycle that `mem_err` rises, that both strobes stay low, and that the MDR load line is still asserted. Stepping back to back through locations 5, 1 and 4 then checks that the flag clears on the very next word.

The second pair is reset and a programmed address. The bench asserts reset while a fully populated word (location 6) is being addressed and expects all-zero outputs at that edge. It then expects the word's normal decode on the first edge after release.

// File: rtl/ucs_pkg.sv
// Package: field widths, register/ALU codes and a word builder for the
// vertical microinstruction control store. Assumes 4-bit codes, 16 lines.
package ucs_pkg;
    localparam int CODE_W = 4;
    localparam int LINES  = 1 << CODE_W;
    localparam int MEM_W  = 2;
    localparam int SEL_W  = 2;
    localparam int COND_W = 3;
    localparam int HEAD_W = 4 * CODE_W + MEM_W + SEL_W + COND_W;

    localparam logic [CODE_W-1:0] R_NONE = 4'd0;
    localparam logic [CODE_W-1:0] R_RS1  = 4'd1;
    localparam logic [CODE_W-1:0] R_RS2  = 4'd2;
    localparam logic [CODE_W-1:0] R_IR   = 4'd3;
    localparam logic [CODE_W-1:0] R_ZERO = 4'd6;
    localparam logic [CODE_W-1:0] R_FOUR = 4'd7;
    localparam logic [CODE_W-1:0] R_PC   = 4'd8;
    localparam logic [CODE_W-1:0] R_MDR  = 4'd9;
    localparam logic [CODE_W-1:0] R_MAR  = 4'd10;

    localparam logic [CODE_W-1:0] F_PASS = 4'd0;
    localparam logic [CODE_W-1:0] F_ADD  = 4'd1;
    localparam logic [CODE_W-1:0] F_SUB  = 4'd2;
    localparam logic [CODE_W-1:0] F_SHR  = 4'd8;

    typedef enum logic [MEM_W-1:0] {
        MEM_IDLE = 2'b00,
        MEM_RD   = 2'b01,
        MEM_WR   = 2'b10,
        MEM_BAD  = 2'b11
    } mem_op_e;

    // Assemble every field of a word except the branch address, MSB first.
    function automatic logic [HEAD_W-1:0] mk_head(
        input logic [CODE_W-1:0] dst,
        input logic [CODE_W-1:0] fn,
        input logic [CODE_W-1:0] s1,
        input logic [CODE_W-1:0] s2,
        input mem_op_e           mem,
        input logic [SEL_W-1:0]  sel,
        input logic [COND_W-1:0] cnd
    );
        return {dst, fn, s1, s2, mem, sel, cnd};
    endfunction
endpackage

// File: rtl/ucs_rom.sv
// Control store: a combinational, preloaded ROM. The fetch routine sits at
// locations 0..3, then come the test-sequence words at 4..7, and every other
// location reads as zero. Assumes ADDR_W >= 5 so that branch target 22 fits.
module ucs_rom
    import ucs_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int WORD_W = HEAD_W + ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    // Look up the stored word for the given address.
    always_comb begin
        case (addr)
            ADDR_W'(0): word = {mk_head(R_MAR,  F_PASS, R_PC,   R_NONE, MEM_IDLE, 2'd0, 3'd0), ADDR_W'(0)};
            ADDR_W'(1): word = {mk_head(R_NONE, F_PASS, R_NONE, R_NONE, MEM_RD,   2'd0, 3'd0), ADDR_W'(0)};
            ADDR_W'(2): word = {mk_head(R_IR,   F_PASS, R_MDR,  R_NONE, MEM_IDLE, 2'd0, 3'd0), ADDR_W'(0)};
            ADDR_W'(3): word = {mk_head(R_PC,   F_ADD,  R_PC,   R_FOUR, MEM_IDLE, 2'd1, 3'd0), ADDR_W'(0)};
            ADDR_W'(4): word = {mk_head(R_NONE, F_PASS, R_NONE, R_NONE, MEM_WR,   2'd0, 3'd0), ADDR_W'(0)};
            ADDR_W'(5): word = {mk_head(R_MDR,  F_PASS, R_MAR,  R_NONE, MEM_BAD,  2'd0, 3'd0), ADDR_W'(0)};
            ADDR_W'(6): word = {mk_head(R_NONE, F_SUB,  R_RS1,  R_ZERO, MEM_IDLE, 2'd2, 3'd5), ADDR_W'(22)};
            ADDR_W'(7): word = {mk_head(R_RS1,  F_SHR,  R_RS1,  R_RS2,  MEM_IDLE, 2'd0, 3'd0), ADDR_W'(0)};
            default:    word = '0;
        endcase
    end
endmodule

// File: rtl/ucs_onehot.sv
// One-hot decoder whose code 0 is reserved for "nothing selected", so line 0
// is never asserted. Assumes LINES == 2**CODE_W.
module ucs_onehot #(
    parameter int CODE_W = 4,
    localparam int LINES = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i == 0) begin : g_none
            // Line 0 stands for "nothing selected" and is never driven high.
            assign lines[i] = 1'b0;
        end else begin : g_sel
            // Line i is asserted only by its own code.
            assign lines[i] = (code == CODE_W'(i));
        end
    end
endmodule

// File: rtl/ucs_memdec.sv
// Memory field decoder: 01 read, 10 write, 00 idle, 11 illegal. An illegal
// code drives no strobe and raises the error flag instead.
module ucs_memdec
    import ucs_pkg::*;
(
    input  logic [MEM_W-1:0] mem,
    output logic             rd,
    output logic             wr,
    output logic             err
);
    // Map the 2-bit field onto the strobes and the error flag.
    always_comb begin
        rd  = 1'b0;
        wr  = 1'b0;
        err = 1'b0;
        case (mem_op_e'(mem))
            MEM_RD:  rd  = 1'b1;
            MEM_WR:  wr  = 1'b1;
            MEM_BAD: err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ucs_decoder.sv
// Top: reads the control store, splits the word into its fields, decodes
// them and registers the complete control word. Outputs trail the address
// by one edge. Synchronous active-low reset clears every output.
module ucs_decoder
    import ucs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   uaddr,
    output logic [LINES-1:0]    dst_load,
    output logic [LINES-1:0]    src1_en,
    output logic [LINES-1:0]    src2_en,
    output logic [CODE_W-1:0]   alu_op,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                mem_err,
    output logic [SEL_W-1:0]    nxt_sel,
    output logic [COND_W-1:0]   cond,
    output logic [ADDR_W-1:0]   br_addr
);
    localparam int WORD_W = HEAD_W + ADDR_W;
    localparam int NFLD   = 3;
    localparam int COND_LO = ADDR_W;
    localparam int SEL_LO  = COND_LO + COND_W;
    localparam int MEM_LO  = SEL_LO + SEL_W;
    localparam int S2_LO   = MEM_LO + MEM_W;
    localparam int S1_LO   = S2_LO + CODE_W;
    localparam int ALU_LO  = S1_LO + CODE_W;
    localparam int DST_LO  = ALU_LO + CODE_W;

    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] code_a [NFLD];
    logic [LINES-1:0]  oh_a   [NFLD];
    logic              rd_c, wr_c, err_c;

    ucs_rom #(.ADDR_W(ADDR_W)) u_rom (.addr(uaddr), .word(word));

    assign code_a[0] = word[DST_LO +: CODE_W];
    assign code_a[1] = word[S1_LO  +: CODE_W];
    assign code_a[2] = word[S2_LO  +: CODE_W];

    for (genvar f = 0; f < NFLD; f++) begin : g_dec
        ucs_onehot #(.CODE_W(CODE_W)) u_oh (.code(code_a[f]), .lines(oh_a[f]));
    end

    ucs_memdec u_mem (.mem(word[MEM_LO +: MEM_W]), .rd(rd_c), .wr(wr_c), .err(err_c));

    // Register the decoded control word; reset clears every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_load <= '0;
            src1_en  <= '0;
            src2_en  <= '0;
            alu_op   <= '0;
            mem_rd   <= 1'b0;
            mem_wr   <= 1'b0;
            mem_err  <= 1'b0;
            nxt_sel  <= '0;
            cond     <= '0;
            br_addr  <= '0;
        end else begin
            dst_load <= oh_a[0];
            src1_en  <= oh_a[1];
            src2_en  <= oh_a[2];
            alu_op   <= word[ALU_LO +: CODE_W];
            mem_rd   <= rd_c;
            mem_wr   <= wr_c;
            mem_err  <= err_c;
            nxt_sel  <= word[SEL_LO +: SEL_W];
            cond     <= word[COND_LO +: COND_W];
            br_addr  <= word[ADDR_W-1:0];
        end
    end

    AST_DST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dst_load)) else $error("dst_load not one-hot"); // R2
    AST_SRC1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(src1_en)) else $error("src1_en not one-hot"); // R3
    AST_SRC2_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(src2_en)) else $error("src2_en not one-hot"); // R3
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)) else $error("read and write together"); // R5
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) mem_err |-> (!mem_rd && !mem_wr)) else $error("strobe with error"); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (dst_load == '0 && src1_en == '0 && src2_en == '0 && !mem_rd && !mem_wr && !mem_err && alu_op == '0)) else $error("reset left outputs set"); // R9
    AST_FETCH_MAR: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(uaddr) == '0) |-> (dst_load[R_MAR] && src1_en[R_PC])) else $error("fetch step 0 wrong"); // R8
endmodule

// File: tb/ucs_decoder_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies an address and queues the expected
// control word; the monitor pops and compares just after each rising edge.
module ucs_decoder_test;
    localparam int AW = 6;

    typedef struct {
        logic [15:0] dst, s1, s2;
        logic [3:0]  alu;
        logic        rd, wr, err;
        logic [1:0]  sel;
        logic [2:0]  cnd;
        logic [5:0]  br;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] uaddr = '0;
    logic [15:0]   dst_load, src1_en, src2_en;
    logic [3:0]    alu_op;
    logic          mem_rd, mem_wr, mem_err;
    logic [1:0]    nxt_sel;
    logic [2:0]    cond;
    logic [5:0]    br_addr;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ucs_decoder #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .uaddr(uaddr),
        .dst_load(dst_load), .src1_en(src1_en), .src2_en(src2_en),
        .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_err(mem_err),
        .nxt_sel(nxt_sel), .cond(cond), .br_addr(br_addr)
    );

    function automatic logic [15:0] oh(input logic [3:0] c);
        return (c == 4'd0) ? 16'd0 : (16'd1 << c);
    endfunction

    // Expected word per R8 / R10, then decode per R2..R7.
    function automatic exp_t model(input logic [AW-1:0] a, input logic rst, input string tag);
        exp_t e;
        logic [3:0] d, f, x, y;
        logic [1:0] m, s;
        logic [2:0] c;
        logic [5:0] b;
        {d, f, x, y, m, s, c, b} = '0;
        case (a)
            6'd0: begin d = 10; x = 8; end
            6'd1: m = 2'b01;
            6'd2: begin d = 3; x = 9; end
            6'd3: begin d = 8; f = 1; x = 8; y = 7; s = 1; end
            6'd4: m = 2'b10;
            6'd5: begin d = 9; x = 10; m = 2'b11; end
            6'd6: begin f = 2; x = 1; y = 6; s = 2; c = 5; b = 22; end
            6'd7: begin d = 1; f = 8; x = 1; y = 2; end
            default: ;
        endcase
        e.dst = oh(d); e.s1 = oh(x); e.s2 = oh(y); e.alu = f;
        e.rd = (m == 2'b01); e.wr = (m == 2'b10); e.err = (m == 2'b11);
        e.sel = s; e.cnd = c; e.br = b; e.tag = tag;
        if (!rst) begin
            e.dst = '0; e.s1 = '0; e.s2 = '0; e.alu = '0;
            e.rd = 0; e.wr = 0; e.err = 0; e.sel = '0; e.cnd = '0; e.br = '0;
        end
        return e;
    endfunction

    task automatic cmp(input string tag, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s/%s: actual %0h expected %0h", tag, req, act, expv);
        end
    endtask

    // Driver: set address and reset at the falling edge, queue the expectation.
    task automatic drive(input logic [AW-1:0] a, input logic rst, input string tag);
        @(negedge clk);
        uaddr = a;
        rst_n = rst;
        q.push_back(model(a, rst, tag));
    endtask

    // Monitor (R1): result of the edge that sampled the address, read 1 ns later.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "R2 dst",  32'(dst_load), 32'(e.dst));
                cmp(e.tag, "R3 src1", 32'(src1_en),  32'(e.s1));
                cmp(e.tag, "R3 src2", 32'(src2_en),  32'(e.s2));
                cmp(e.tag, "R4 alu",  32'(alu_op),   32'(e.alu));
                cmp(e.tag, "R5 mem",  32'({mem_rd, mem_wr}), 32'({e.rd, e.wr}));
                cmp(e.tag, "R6 err",  32'(mem_err),  32'(e.err));
                cmp(e.tag, "R7 ctl",  32'({nxt_sel, cond, br_addr}), 32'({e.sel, e.cnd, e.br}));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive(6'd3, 1'b0, "R9 reset");
        drive(6'd6, 1'b0, "R9 reset");
        for (int i = 0; i < 8; i++) drive(AW'(i), 1'b1, "R8 R1 store");
        drive(6'd9,  1'b1, "R10 empty");
        drive(6'd63, 1'b1, "R10 empty");
        drive(6'd6,  1'b0, "R9 mid-run reset");
        drive(6'd6,  1'b1, "R7 after release");
        drive(6'd5,  1'b1, "R6 illegal with load");
        drive(6'd1,  1'b1, "R5 read after error");
        drive(6'd4,  1'b1, "R5 write");
        drive(6'd0,  1'b1, "R2 fetch");
        drive(6'd2,  1'b1, "R3 fetch");
        drive(6'd7,  1'b1, "R4 shift");
        drive(6'd3,  1'b1, "R1 fetch step");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule